// File: doc/BRIEF.md
# Prioritized external interrupt controller

This block gathers up to 32 external interrupt lines into one interrupt request for a CPU. Each live channel is resynchronized to the block clock. A per-channel trigger is fixed at synthesis time: either a level trigger or an edge trigger, with either polarity. A channel that fires while its enable bit is set is latched into a pending register. The CPU request is raised while any pending bit is set.

Software uses a small register bus with a one-cycle read latency. It arms channels through the enable register and clears serviced channels by writing zeros to the pending register. The source register reports the ID of the pending channel with the highest priority, where a lower index wins. Writing any value to the source register acknowledges the interrupt. The acknowledge drops the request for one cycle so that the CPU sees a fresh rising request if work remains.

None of the interfaces carries a data stream, so every pin is a plain control or status signal and there is no valid/ready handshake. A bus access completes in the cycle its strobe is sampled and cannot be stalled.

Top module: `irq_funnel`

## Requirements
- R1: After reset, the enable and pending registers are zero, the source register reads 0 and `cpu_irq` is low.
- R2: A read strobe at byte address A returns its data on `bus_rdata` one cycle later. Address bits [3:2] select the register: 0 is enable, 1 is pending, 2 is source and 3 is reserved. The reserved slot reads zero. Enable and pending bits at or above `N_CH` read as zero.
- R3: A channel becomes pending only if its enable bit is set in the cycle its trigger fires. A channel that is already pending stays pending after its enable bit is cleared.
- R4: Writing the pending register clears each bit written as 0 and keeps each bit written as 1. If a trigger fires in the same cycle as a clear, the bit ends up set.
- R5: A level-triggered channel fires while its synchronized input equals its polarity bit (1 means high, 0 means low). A level input applied before clock edge k sets pending after edge k+2.
- R6: An edge-triggered channel fires once per transition. Polarity 1 selects a rising edge and polarity 0 a falling edge. An input held steady after a clear does not set the bit again.
- R7: `cpu_irq` is a register that goes high one cycle after the pending register becomes non-zero, and it is low whenever the pending register was zero in the previous cycle.
- R8: The source register holds the lowest index among pending channels in bits [4:0], with all higher bits zero. It reads 0 when nothing is pending.
- R9: A write of any value to the source register forces `cpu_irq` low in the following cycle. After that cycle the request is again derived from the pending register.
- R10: Input bits at or above `N_CH`, and trigger configuration bits at or above `N_CH`, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 32 | External interrupt lines, channel i on bit i |
| bus_en | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 4 | Byte address; bits [3:2] pick the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle after a read strobe |
| cpu_irq | output | 1 | Interrupt request to the CPU |

## Verification
Timing is counted from the clock edge at which each stimulus is sampled:

- A line change sampled at edge k reaches the pending register after edge k+2 and raises `cpu_irq` after edge k+3.
- A register read returns its data after the edge that sampled the strobe.
- An acknowledge pulls `cpu_irq` low at the next edge, and the request is raised again one edge later.

The bench changes all inputs on falling edges and samples on falling edges. It checks the interrupt pipeline at the exact third and fourth edges. Every other check is made only after waits longer than these latencies.

// File: rtl/irq_funnel_pkg.sv
package irq_funnel_pkg;

  localparam int unsigned XW  = 32;
  localparam int unsigned IDW = 5;

  typedef enum logic [1:0] {
    SEL_ENABLE = 2'd0,
    SEL_PEND   = 2'd1,
    SEL_SRC    = 2'd2,
    SEL_RSVD   = 2'd3
  } reg_sel_e;

  // Mask with the low n bits set.
  function automatic logic [XW-1:0] ch_mask(input int unsigned n);
    logic [XW-1:0] m;
    m = '0;
    for (int unsigned i = 0; i < XW; i++) begin
      if (i < n) m[i] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/irq_trigger_front.sv
module irq_trigger_front
  import irq_funnel_pkg::*;
#(
  parameter int unsigned   N_CH      = 32,
  parameter logic [XW-1:0] TRIG_EDGE = '0,
  parameter logic [XW-1:0] TRIG_POL  = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [XW-1:0] lines_i,
  output logic [XW-1:0] fire_o
);

  for (genvar g = 0; g < XW; g++) begin : g_ch
    if (g < N_CH) begin : g_live
      logic s_meta, s_now;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          s_meta <= 1'b0;
          s_now  <= 1'b0;
        end else begin
          s_meta <= lines_i[g];
          s_now  <= s_meta;
        end
      end

      if (TRIG_EDGE[g]) begin : g_edge
        logic s_prev;
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) s_prev <= 1'b0;
          else        s_prev <= s_now;
        end
        if (TRIG_POL[g]) begin : g_rise
          assign fire_o[g] = s_now & ~s_prev;
        end else begin : g_fall
          assign fire_o[g] = ~s_now & s_prev;
        end
      end else begin : g_level
        if (TRIG_POL[g]) begin : g_high
          assign fire_o[g] = s_now;
        end else begin : g_low
          assign fire_o[g] = ~s_now;
        end
      end
    end else begin : g_dead
      logic unused_line;
      assign unused_line = lines_i[g];
      assign fire_o[g]   = 1'b0;
    end
  end

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int unsigned W   = 32,
  parameter int unsigned IDW = $clog2(W)
) (
  input  logic [W-1:0]   vec_i,
  output logic           any_o,
  output logic [IDW-1:0] id_o
);

  always_comb begin
    id_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) id_o = IDW'(i);
    end
  end

  assign any_o = |vec_i;

endmodule

// File: rtl/irq_funnel.sv
module irq_funnel
  import irq_funnel_pkg::*;
#(
  parameter int unsigned   N_CH      = 32,
  parameter logic [XW-1:0] TRIG_EDGE = '0,
  parameter logic [XW-1:0] TRIG_POL  = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [XW-1:0] irq_in,
  input  logic          bus_en,
  input  logic          bus_we,
  input  logic [3:0]    bus_addr,
  input  logic [XW-1:0] bus_wdata,
  output logic [XW-1:0] bus_rdata,
  output logic          cpu_irq
);

  localparam logic [XW-1:0] LIVE = ch_mask(N_CH);

  logic [XW-1:0]  fire;
  logic [XW-1:0]  ier_q, pend_q, pend_d;
  logic [IDW-1:0] src_id;
  logic           any_pend;
  logic           wr, rd, ack;
  reg_sel_e       sel;
  logic [1:0]     unused_byte;

  assign unused_byte = bus_addr[1:0];
  assign sel = reg_sel_e'(bus_addr[3:2]);
  assign wr  = bus_en & bus_we;
  assign rd  = bus_en & ~bus_we;
  assign ack = wr && (sel == SEL_SRC);

  irq_trigger_front #(
    .N_CH      (N_CH),
    .TRIG_EDGE (TRIG_EDGE),
    .TRIG_POL  (TRIG_POL)
  ) u_front (
    .clk     (clk),
    .rst_n   (rst_n),
    .lines_i (irq_in),
    .fire_o  (fire)
  );

  irq_prio_pick #(
    .W   (XW),
    .IDW (IDW)
  ) u_pick (
    .vec_i (pend_q),
    .any_o (any_pend),
    .id_o  (src_id)
  );

  always_comb begin
    pend_d = pend_q;
    if (wr && sel == SEL_PEND) pend_d = pend_d & bus_wdata;
    pend_d = (pend_d | (fire & ier_q)) & LIVE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ier_q     <= '0;
      pend_q    <= '0;
      cpu_irq   <= 1'b0;
      bus_rdata <= '0;
    end else begin
      pend_q  <= pend_d;
      cpu_irq <= ack ? 1'b0 : any_pend;
      if (wr && sel == SEL_ENABLE) ier_q <= bus_wdata & LIVE;
      if (rd) begin
        unique case (sel)
          SEL_ENABLE: bus_rdata <= ier_q;
          SEL_PEND:   bus_rdata <= pend_q;
          SEL_SRC:    bus_rdata <= {{(XW-IDW){1'b0}}, src_id};
          default:    bus_rdata <= '0;
        endcase
      end
    end
  end

endmodule

// File: rtl/irq_funnel_chk.sv
module irq_funnel_chk
  import irq_funnel_pkg::*;
#(
  parameter int unsigned N_CH = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic [XW-1:0]  ier_q,
  input logic [XW-1:0]  pend_q,
  input logic [IDW-1:0] src_id,
  input logic           ack,
  input logic           cpu_irq
);

  localparam logic [XW-1:0] LIVE = ch_mask(N_CH);

  a_r9_ack_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !cpu_irq);

  a_r7_irq_needs_pend: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> ($past(pend_q) != '0));

  a_r3_enable_gates: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((pend_q & ~$past(pend_q) & ~$past(ier_q)) == '0));

  a_r8_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q != '0) |->
      (pend_q[src_id] && ((pend_q & ((32'd1 << src_id) - 32'd1)) == '0)));

  a_r8_idle_id_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q == '0) |-> (src_id == '0));

  a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q | ier_q) & ~LIVE) == '0);

endmodule

bind irq_funnel irq_funnel_chk #(.N_CH(N_CH)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .ier_q   (ier_q),
  .pend_q  (pend_q),
  .src_id  (src_id),
  .ack     (ack),
  .cpu_irq (cpu_irq)
);

// File: tb/test_irq_funnel.sv
`timescale 1ns/1ps
module test_irq_funnel;

  localparam logic [31:0] IDLE = 32'h0000_000A;
  localparam logic [31:0] ACT  = 32'h0000_0035;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_in = IDLE;
  logic        bus_en = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        cpu_irq;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_funnel #(
    .N_CH      (6),
    .TRIG_EDGE (32'hFFFF_FF2C),
    .TRIG_POL  (32'h0000_0035)
  ) i_irq_funnel (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_in    (irq_in),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cpu_irq   (cpu_irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_en = 1'b0;
    d = bus_rdata;
  endtask

  function automatic logic [31:0] lowest(input logic [31:0] m);
    for (int i = 0; i < 32; i++) if (m[i]) return 32'(i);
    return 32'd0;
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d;
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // R1 reset state
    chk("R1 irq", {31'b0, cpu_irq}, 32'd0);
    bus_rd(4'h0, d); chk("R1 enable", d, 32'd0);
    bus_rd(4'h4, d); chk("R1 pending", d, 32'd0);
    bus_rd(4'h8, d); chk("R1 source", d, 32'd0);

    // R2 reserved slot and masked upper bits
    bus_rd(4'hC, d); chk("R2 reserved", d, 32'd0);
    bus_wr(4'h0, 32'hFFFF_FFFF);
    bus_rd(4'h0, d); chk("R2 enable mask", d, 32'h3F);

    // R10 upper inputs ignored
    irq_in = IDLE | 32'hFFFF_FFC0; tick(5);
    irq_in = IDLE; tick(5);
    bus_rd(4'h4, d); chk("R10 pending", d, 32'd0);
    chk("R10 irq", {31'b0, cpu_irq}, 32'd0);
    bus_wr(4'h0, 32'd0);

    // R5 / R7 pipeline timing on level-high channel 0
    bus_wr(4'h0, 32'h1);
    irq_in = IDLE | 32'h1;
    tick(3); chk("R7 irq not yet", {31'b0, cpu_irq}, 32'd0);
    tick(1); chk("R7 irq raised", {31'b0, cpu_irq}, 32'd1);
    bus_rd(4'h4, d); chk("R5 pending", d, 32'h1);
    bus_rd(4'h8, d); chk("R8 source", d, 32'd0);

    // R3 retention after disable
    bus_wr(4'h0, 32'd0);
    bus_rd(4'h4, d); chk("R3 retained", d, 32'h1);
    irq_in = IDLE; tick(4);
    bus_wr(4'h4, 32'd0);
    bus_rd(4'h4, d); chk("R4 cleared", d, 32'd0);
    tick(2); chk("R7 irq low", {31'b0, cpu_irq}, 32'd0);

    // R3 disabled channel never pends
    irq_in = IDLE | 32'h1; tick(5);
    bus_rd(4'h4, d); chk("R3 disabled", d, 32'd0);
    chk("R3 irq", {31'b0, cpu_irq}, 32'd0);
    irq_in = IDLE; tick(4);

    // R4 trigger beats clear
    bus_wr(4'h0, 32'h1);
    irq_in = IDLE | 32'h1; tick(5);
    bus_wr(4'h4, 32'd0);
    bus_rd(4'h4, d); chk("R4 set wins", d, 32'h1);
    bus_wr(4'h0, 32'd0);
    irq_in = IDLE; tick(4);
    bus_wr(4'h4, 32'd0);

    // R6 rising edge one-shot on channel 2
    bus_wr(4'h0, 32'h4);
    irq_in = IDLE | 32'h4; tick(5);
    bus_rd(4'h4, d); chk("R6 rise", d, 32'h4);
    bus_wr(4'h4, 32'd0); tick(5);
    bus_rd(4'h4, d); chk("R6 rise once", d, 32'd0);
    irq_in = IDLE; tick(4);

    // R6 falling edge one-shot on channel 3
    bus_wr(4'h0, 32'h8);
    irq_in = IDLE & ~32'h8; tick(5);
    bus_rd(4'h4, d); chk("R6 fall", d, 32'h8);
    bus_wr(4'h4, 32'd0); tick(5);
    bus_rd(4'h4, d); chk("R6 fall once", d, 32'd0);
    irq_in = IDLE; tick(4);
    bus_rd(4'h4, d); chk("R6 no rise event", d, 32'd0);
    bus_wr(4'h0, 32'd0);

    // R9 acknowledge
    bus_wr(4'h0, 32'h1);
    irq_in = IDLE | 32'h1; tick(5);
    chk("R9 irq before", {31'b0, cpu_irq}, 32'd1);
    bus_wr(4'h8, 32'h1234);
    chk("R9 irq dropped", {31'b0, cpu_irq}, 32'd0);
    tick(1); chk("R9 irq again", {31'b0, cpu_irq}, 32'd1);
    bus_wr(4'h0, 32'd0);
    irq_in = IDLE; tick(4);
    bus_wr(4'h4, 32'd0); tick(2);
    bus_wr(4'h8, 32'd0); tick(2);
    chk("R9 idle after ack", {31'b0, cpu_irq}, 32'd0);

    // R8 / R3 / R5 / R6 sweep of every enable pattern
    for (int m = 0; m < 64; m++) begin
      bus_wr(4'h0, 32'(m));
      irq_in = ACT; tick(5);
      bus_rd(4'h4, d); chk("R3 sweep pending", d, 32'(m));
      bus_rd(4'h8, d); chk("R8 sweep source", d, lowest(32'(m)));
      chk("R7 sweep irq", {31'b0, cpu_irq}, {31'b0, (m != 0)});
      bus_wr(4'h0, 32'd0);
      irq_in = IDLE; tick(4);
      bus_wr(4'h4, 32'd0); tick(2);
    end

    // R4 write-one keeps
    bus_wr(4'h0, 32'h11);
    irq_in = ACT; tick(5);
    bus_wr(4'h0, 32'd0);
    irq_in = IDLE; tick(4);
    bus_wr(4'h4, 32'hFFFF_FFFE);
    bus_rd(4'h4, d); chk("R4 keep ones", d, 32'h10);
    bus_rd(4'h8, d); chk("R8 next source", d, 32'd4);
    bus_wr(4'h4, 32'd0);
    bus_rd(4'h8, d); chk("R8 empty source", d, 32'd0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule